// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the byte-wide register window of an SMBus host controller. A processor-side port reads and writes bytes in a 16-byte window. The window holds a status register, a control register, the host address, command and two data bytes, and a block-data port that walks a 32-entry byte buffer. The block decodes the offset, keeps the status bits, clears them when status is written, launches host cycles, records abort requests and drives a level interrupt.

The bus signalling itself is left to a separate transaction engine. The block gives that engine the cycle type, device address, read/write flag, command and data bytes, together with a one-cycle start strobe. The engine reads the block buffer through its own read port and may write it through its own write port. It reports back with one-cycle completion, protocol-error, collision and timeout pulses, and it can load read results into the two data bytes.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset every offset of the window reads 0x00, the interrupt is low and no start strobe is issued.
- R2: Bytes written at offset 0x4 (host address), 0x8 (command), 0x6 (data low) and 0x7 (data high) read back unchanged. They are presented to the engine, where the device address is address bits [7:1] and the read flag is address bit 0. A result load from the engine replaces both data bytes.
- R3: The control register at offset 0x2 stores the whole written byte, but reads return only its bits [4:0]. Bits [2:0] are the cycle type, bit 3 is start, bit 4 is interrupt enable and bit 5 is abort.
- R4: A control write with bit 3 set and a cycle type of 0, 1, 2, 3 or 5 gives exactly one start strobe, in the cycle after the write. It also sets busy (status bit 3) until the engine reports an outcome.
- R5: A control write with bit 3 set and a cycle type of 4, 6 or 7 gives no start strobe and sets protocol error (status bit 2) at once.
- R6: A control write with bit 5 set sets the abort flag (status bit 0).
- R7: Engine pulses set status bits: completion sets bit 4, protocol error sets bit 2, collision sets bit 1 and timeout sets bit 5. Each of these pulses clears busy.
- R8: A status write (offset 0x0) whose byte has any of the bits 0, 1, 2, 4 or 5 set clears the whole status register and returns the block index to 0.
- R9: A status write with none of those bits set forces the status register to 0x10 (completion only) and returns the block index to 0.
- R10: Each read or write at offset 0x9 accesses buffer[index] and then advances the index. After entry 31 the index goes back to 0.
- R11: An engine outcome pulse raises the interrupt when control bit 4 is set. A start write with bit 4 set raises it when a clearable status bit is already set after that write.
- R12: A status write raises the interrupt when control bit 4 is set and the written byte has a clearable bit that is currently clear in status. Any other status write lowers the interrupt.
- R13: Offset 0x1 reads the summary event flag in bit 3, which is set whenever any clearable status bit is set. Busy alone does not set it.
- R14: Offsets 0x1, 0x3, 0x5 and 0xA to 0xF ignore writes, and every offset other than 0x0 to 0x2 and 0x4 to 0x9 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the block index at offset 0x9) |
| bus_ofs | input | 4 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and state |
| irq | output | 1 | Level interrupt |
| xact_start | output | 1 | One-cycle start strobe to the engine |
| xact_type | output | 3 | Cycle type from control bits [2:0] |
| xact_dev | output | 7 | Device address |
| xact_rnw | output | 1 | Read flag |
| xact_cmd | output | 8 | Command byte |
| xact_data0 | output | 8 | Data low byte |
| xact_data1 | output | 8 | Data high byte |
| eng_buf_raddr | input | 5 | Engine read address into the block buffer |
| eng_buf_rdata | output | 8 | Block buffer byte at eng_buf_raddr |
| eng_buf_we | input | 1 | Engine write strobe into the block buffer |
| eng_buf_waddr | input | 5 | Engine write address |
| eng_buf_wdata | input | 8 | Engine write data |
| eng_res_we | input | 1 | Load read results into both data bytes |
| eng_res_d0 | input | 8 | Result low byte |
| eng_res_d1 | input | 8 | Result high byte |
| eng_done | input | 1 | Completion pulse |
| eng_perr | input | 1 | Protocol error pulse |
| eng_coll | input | 1 | Collision pulse |
| eng_tmo | input | 1 | Timeout pulse |

## Verification
The bench writes 33 bytes through the block port and reads entry 0 through the engine port. An index that failed to wrap, or that wrapped one entry late, would leave the first byte in place or write outside the buffer. The interrupt is driven through the full sequence: a raise on completion, then a status write that names only bits already set (which must lower it), a write that brings in a new bit (which must raise it), and a plain write (which must lower it and force status to 0x10). A design that raised the line on any write, or compared the byte against the wrong bits, would fail one of these steps. Start writes with cycle types 4, 6 and 7 must give no strobe and an immediate protocol error. Reads of the control register with bits 5 to 7 set must come back masked.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

   // register offsets inside the 16-byte window (decoded by the host bus)
   localparam logic [3:0] OFS_STAT_LO = 4'h0;
   localparam logic [3:0] OFS_STAT_HI = 4'h1;
   localparam logic [3:0] OFS_CTL     = 4'h2;
   localparam logic [3:0] OFS_HADDR   = 4'h4;
   localparam logic [3:0] OFS_DLO     = 4'h6;
   localparam logic [3:0] OFS_DHI     = 4'h7;
   localparam logic [3:0] OFS_CMD     = 4'h8;
   localparam logic [3:0] OFS_BLK     = 4'h9;

   // status bit positions
   localparam int ST_ABORT = 0;
   localparam int ST_COLL  = 1;
   localparam int ST_PERR  = 2;
   localparam int ST_BUSY  = 3;
   localparam int ST_DONE  = 4;
   localparam int ST_TMO   = 5;
   localparam int ST_W     = 6;

   // bits that a status write clears and that feed the event summary
   localparam logic [ST_W-1:0] ST_CLEARABLE = 6'b11_0111;
   localparam logic [ST_W-1:0] ST_FORCED    = 6'b01_0000;

   // control bit positions
   localparam int CTL_GO    = 3;
   localparam int CTL_IEN   = 4;
   localparam int CTL_ABORT = 5;
   localparam logic [7:0] CTL_READ_MASK = 8'h1F;

   typedef enum logic [2:0] {
      CYC_QUICK = 3'd0,
      CYC_BYTE  = 3'd1,
      CYC_BDATA = 3'd2,
      CYC_WDATA = 3'd3,
      CYC_PCALL = 3'd4,
      CYC_BLOCK = 3'd5
   } cyc_type_e;

   function automatic logic cyc_supported(input logic [2:0] t);
      return (t == CYC_QUICK) || (t == CYC_BYTE) || (t == CYC_BDATA) ||
             (t == CYC_WDATA) || (t == CYC_BLOCK);
   endfunction

endpackage

// File: rtl/smbh_block_buf.sv
module smbh_block_buf #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              idx_clr,
   input  logic [IDX_W-1:0]  eng_raddr,
   output logic [DATA_W-1:0] eng_rdata,
   input  logic              eng_we,
   input  logic [IDX_W-1:0]  eng_waddr,
   input  logic [DATA_W-1:0] eng_wdata
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("smbh_block_buf: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  idx_inc;
   logic              access;

   assign access = host_wr | host_rd;

   if ((1 << IDX_W) == DEPTH) begin : g_wrap_pow2
      assign idx_inc = idx + 1'b1;
   end else begin : g_wrap_cmp
      assign idx_inc = (idx == LAST) ? '0 : idx + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (idx_clr) begin
         idx <= '0;
      end else if (access) begin
         idx <= idx_inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (host_wr) begin
         mem[idx] <= host_wdata;
      end else if (eng_we) begin
         mem[eng_waddr] <= eng_wdata;
      end
   end

   assign host_rdata = mem[idx];
   assign eng_rdata  = mem[eng_raddr];

   AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !idx_clr && idx == LAST) |=> (idx == '0)); // R10
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !idx_clr && idx != LAST) |=> (idx == $past(idx) + 1'b1)); // R10
   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!access && !idx_clr) |=> $stable(idx)); // R10

endmodule

// File: rtl/smbh_status.sv
module smbh_status
   import smbh_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stat_wr,
   input  logic            ctl_wr,
   input  logic [7:0]      wdata,
   input  logic            ien,
   input  logic            launch_ok,
   input  logic            launch_bad,
   input  logic            eng_done,
   input  logic            eng_perr,
   input  logic            eng_coll,
   input  logic            eng_tmo,
   output logic [ST_W-1:0] stat,
   output logic            irq
);

   logic [ST_W-1:0] stat_nxt;
   logic            irq_nxt;
   logic            eng_any;
   logic [ST_W-1:0] wr_clr_bits;

   assign eng_any     = eng_done | eng_perr | eng_coll | eng_tmo;
   assign wr_clr_bits = wdata[ST_W-1:0] & ST_CLEARABLE;

   always_comb begin
      stat_nxt = stat;
      if (stat_wr) begin
         stat_nxt = (|wr_clr_bits) ? '0 : ST_FORCED;
      end
      if (ctl_wr) begin
         if (wdata[CTL_ABORT]) stat_nxt[ST_ABORT] = 1'b1;
         if (launch_ok)        stat_nxt[ST_BUSY]  = 1'b1;
         if (launch_bad)       stat_nxt[ST_PERR]  = 1'b1;
      end
      if (eng_any)  stat_nxt[ST_BUSY] = 1'b0;
      if (eng_done) stat_nxt[ST_DONE] = 1'b1;
      if (eng_perr) stat_nxt[ST_PERR] = 1'b1;
      if (eng_coll) stat_nxt[ST_COLL] = 1'b1;
      if (eng_tmo)  stat_nxt[ST_TMO]  = 1'b1;
   end

   always_comb begin
      irq_nxt = irq;
      if (stat_wr) begin
         irq_nxt = ien && |(wr_clr_bits & ~(stat & ST_CLEARABLE));
      end
      if (ctl_wr && wdata[CTL_GO] && wdata[CTL_IEN] && |(stat_nxt & ST_CLEARABLE)) begin
         irq_nxt = 1'b1;
      end
      if (eng_any && ien) begin
         irq_nxt = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         irq  <= 1'b0;
      end else begin
         stat <= stat_nxt;
         irq  <= irq_nxt;
      end
   end

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && (|(wdata[ST_W-1:0] & ST_CLEARABLE)) && !eng_any) |=> (stat == '0)); // R8
   AST_FORCE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !(|(wdata[ST_W-1:0] & ST_CLEARABLE)) && !eng_any) |=> (stat == ST_FORCED)); // R9
   AST_ABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[CTL_ABORT] && !stat_wr) |=> stat[ST_ABORT]); // R6
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(stat_wr || ctl_wr || eng_any)); // R11
   AST_OUTCOME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_any && !ctl_wr && !stat_wr) |=> !stat[ST_BUSY]); // R7

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
   import smbh_pkg::*;
#(
   parameter int OFS_W     = 4,
   parameter int BUF_DEPTH = 32,
   localparam int BIDX_W   = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [OFS_W-1:0]  bus_ofs,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq,
   output logic              xact_start,
   output logic [2:0]        xact_type,
   output logic [6:0]        xact_dev,
   output logic              xact_rnw,
   output logic [7:0]        xact_cmd,
   output logic [7:0]        xact_data0,
   output logic [7:0]        xact_data1,
   input  logic [BIDX_W-1:0] eng_buf_raddr,
   output logic [7:0]        eng_buf_rdata,
   input  logic              eng_buf_we,
   input  logic [BIDX_W-1:0] eng_buf_waddr,
   input  logic [7:0]        eng_buf_wdata,
   input  logic              eng_res_we,
   input  logic [7:0]        eng_res_d0,
   input  logic [7:0]        eng_res_d1,
   input  logic              eng_done,
   input  logic              eng_perr,
   input  logic              eng_coll,
   input  logic              eng_tmo
);

   if (OFS_W < 4) begin : g_bad_ofs
      $error("smbus_host_regs: OFS_W must cover the 16-byte window");
   end

   // decode
   logic sel_stat, sel_stat_hi, sel_ctl, sel_haddr, sel_dlo, sel_dhi, sel_cmd, sel_blk;
   assign sel_stat    = (bus_ofs == OFS_W'(OFS_STAT_LO));
   assign sel_stat_hi = (bus_ofs == OFS_W'(OFS_STAT_HI));
   assign sel_ctl     = (bus_ofs == OFS_W'(OFS_CTL));
   assign sel_haddr   = (bus_ofs == OFS_W'(OFS_HADDR));
   assign sel_dlo     = (bus_ofs == OFS_W'(OFS_DLO));
   assign sel_dhi     = (bus_ofs == OFS_W'(OFS_DHI));
   assign sel_cmd     = (bus_ofs == OFS_W'(OFS_CMD));
   assign sel_blk     = (bus_ofs == OFS_W'(OFS_BLK));

   logic [7:0] ctl_q, haddr_q, cmd_q, d0_q, d1_q;
   logic       start_q;
   logic       ctl_wr, stat_wr, go_wr, launch_ok, launch_bad;
   logic [ST_W-1:0] stat;
   logic [7:0] blk_rdata;
   logic       event_flag;

   assign ctl_wr     = bus_wr && sel_ctl;
   assign stat_wr    = bus_wr && sel_stat;
   assign go_wr      = ctl_wr && bus_wdata[CTL_GO];
   assign launch_ok  = go_wr && cyc_supported(bus_wdata[2:0]);
   assign launch_bad = go_wr && !cyc_supported(bus_wdata[2:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         haddr_q <= '0;
         cmd_q   <= '0;
         d0_q    <= '0;
         d1_q    <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= launch_ok;
         if (ctl_wr)              ctl_q   <= bus_wdata;
         if (bus_wr && sel_haddr) haddr_q <= bus_wdata;
         if (bus_wr && sel_cmd)   cmd_q   <= bus_wdata;
         if (bus_wr && sel_dlo)   d0_q    <= bus_wdata;
         else if (eng_res_we)     d0_q    <= eng_res_d0;
         if (bus_wr && sel_dhi)   d1_q    <= bus_wdata;
         else if (eng_res_we)     d1_q    <= eng_res_d1;
      end
   end

   smbh_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .stat_wr    (stat_wr),
      .ctl_wr     (ctl_wr),
      .wdata      (bus_wdata),
      .ien        (ctl_q[CTL_IEN]),
      .launch_ok  (launch_ok),
      .launch_bad (launch_bad),
      .eng_done   (eng_done),
      .eng_perr   (eng_perr),
      .eng_coll   (eng_coll),
      .eng_tmo    (eng_tmo),
      .stat       (stat),
      .irq        (irq)
   );

   smbh_block_buf #(
      .DEPTH  (BUF_DEPTH),
      .DATA_W (8)
   ) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (bus_wr && sel_blk),
      .host_rd    (bus_rd && sel_blk),
      .host_wdata (bus_wdata),
      .host_rdata (blk_rdata),
      .idx_clr    (stat_wr),
      .eng_raddr  (eng_buf_raddr),
      .eng_rdata  (eng_buf_rdata),
      .eng_we     (eng_buf_we),
      .eng_waddr  (eng_buf_waddr),
      .eng_wdata  (eng_buf_wdata)
   );

   assign event_flag = |(stat & ST_CLEARABLE);

   always_comb begin
      bus_rdata = 8'h00;
      if (sel_stat)    bus_rdata = {{(8 - ST_W){1'b0}}, stat};
      if (sel_stat_hi) bus_rdata = {4'b0000, event_flag, 3'b000};
      if (sel_ctl)     bus_rdata = ctl_q & CTL_READ_MASK;
      if (sel_haddr)   bus_rdata = haddr_q;
      if (sel_dlo)     bus_rdata = d0_q;
      if (sel_dhi)     bus_rdata = d1_q;
      if (sel_cmd)     bus_rdata = cmd_q;
      if (sel_blk)     bus_rdata = blk_rdata;
   end

   assign xact_start = start_q;
   assign xact_type  = ctl_q[2:0];
   assign xact_dev   = haddr_q[7:1];
   assign xact_rnw   = haddr_q[0];
   assign xact_cmd   = cmd_q;
   assign xact_data0 = d0_q;
   assign xact_data1 = d1_q;

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      xact_start |=> !xact_start); // R4
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      xact_start |-> stat[ST_BUSY]); // R4
   AST_START_TYPE_OK: assert property (@(posedge clk) disable iff (!rst_n)
      xact_start |-> cyc_supported(xact_type)); // R5
   AST_CTL_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && sel_ctl) |-> (bus_rdata[7:5] == 3'b000)); // R3

endmodule

// File: tb/test_smbus_host_regs.sv
module test_smbus_host_regs;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 0, bus_rd = 0;
   logic [3:0] bus_ofs = 0;
   logic [7:0] bus_wdata = 0;
   logic [7:0] bus_rdata;
   logic       irq, xact_start, xact_rnw;
   logic [2:0] xact_type;
   logic [6:0] xact_dev;
   logic [7:0] xact_cmd, xact_data0, xact_data1;
   logic [4:0] eng_buf_raddr = 0, eng_buf_waddr = 0;
   logic [7:0] eng_buf_rdata, eng_buf_wdata = 0;
   logic       eng_buf_we = 0, eng_res_we = 0;
   logic [7:0] eng_res_d0 = 0, eng_res_d1 = 0;
   logic       eng_done = 0, eng_perr = 0, eng_coll = 0, eng_tmo = 0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   smbus_host_regs i_smbus_host_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .xact_start(xact_start), .xact_type(xact_type),
      .xact_dev(xact_dev), .xact_rnw(xact_rnw), .xact_cmd(xact_cmd),
      .xact_data0(xact_data0), .xact_data1(xact_data1),
      .eng_buf_raddr(eng_buf_raddr), .eng_buf_rdata(eng_buf_rdata),
      .eng_buf_we(eng_buf_we), .eng_buf_waddr(eng_buf_waddr),
      .eng_buf_wdata(eng_buf_wdata), .eng_res_we(eng_res_we),
      .eng_res_d0(eng_res_d0), .eng_res_d1(eng_res_d1),
      .eng_done(eng_done), .eng_perr(eng_perr), .eng_coll(eng_coll),
      .eng_tmo(eng_tmo)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1; bus_ofs = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_rd = 1; bus_ofs = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: eng_done = 1;
         1: eng_perr = 1;
         2: eng_coll = 1;
         default: eng_tmo = 1;
      endcase
      @(negedge clk);
      eng_done = 0; eng_perr = 0; eng_coll = 0; eng_tmo = 0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 irq", irq, 0);
      chk("R1 start", xact_start, 0);
      for (int a = 0; a < 16; a++) begin
         rd(a[3:0], v);
         chk("R1 window", v, 8'h00);
      end
   endtask

   task automatic t_regs();
      logic [7:0] v;
      wr(4'h4, 8'hA5); wr(4'h8, 8'h3C); wr(4'h6, 8'h11); wr(4'h7, 8'h22);
      rd(4'h4, v); chk("R2 haddr", v, 8'hA5);
      rd(4'h8, v); chk("R2 cmd", v, 8'h3C);
      rd(4'h6, v); chk("R2 dlo", v, 8'h11);
      rd(4'h7, v); chk("R2 dhi", v, 8'h22);
      chk("R2 dev", xact_dev, 7'h52);
      chk("R2 rnw", xact_rnw, 1);
      chk("R2 cmd out", xact_cmd, 8'h3C);
      chk("R2 data out", {xact_data1, xact_data0}, 16'h2211);
      @(negedge clk);
      eng_res_we = 1; eng_res_d0 = 8'h77; eng_res_d1 = 8'h88;
      @(negedge clk);
      eng_res_we = 0;
      rd(4'h6, v); chk("R2 result lo", v, 8'h77);
      rd(4'h7, v); chk("R2 result hi", v, 8'h88);
   endtask

   task automatic t_ctl_read();
      logic [7:0] v;
      wr(4'h2, 8'hE7);
      rd(4'h2, v); chk("R3 masked", v, 8'h07);
      wr(4'h2, 8'h14);
      rd(4'h2, v); chk("R3 plain", v, 8'h14);
      wr(4'h2, 8'h00);
   endtask

   task automatic t_launch();
      logic [7:0] v;
      logic [2:0] good [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5};
      foreach (good[i]) begin
         wr(4'h0, 8'h37);
         wr(4'h2, {5'b00001, good[i]});
         chk("R4 strobe", xact_start, 1);
         chk("R4 type", xact_type, good[i]);
         @(negedge clk);
         chk("R4 one cycle", xact_start, 0);
         rd(4'h0, v); chk("R4 busy", v, 8'h08);
         rd(4'h1, v); chk("R13 busy no event", v, 8'h00);
         pulse(0);
         rd(4'h0, v); chk("R7 done", v, 8'h10);
         rd(4'h1, v); chk("R13 event", v, 8'h08);
      end
      for (int t = 4; t < 8; t++) begin
         if (t == 5) continue;
         wr(4'h0, 8'h37);
         wr(4'h2, {5'b00001, t[2:0]});
         chk("R5 no strobe", xact_start, 0);
         rd(4'h0, v); chk("R5 perr", v, 8'h04);
      end
   endtask

   task automatic t_abort_flags();
      logic [7:0] v;
      wr(4'h2, 8'h00);
      wr(4'h0, 8'h37);
      wr(4'h2, 8'h20);
      rd(4'h0, v); chk("R6 abort", v, 8'h01);
      wr(4'h0, 8'h37);
      pulse(2); rd(4'h0, v); chk("R7 coll", v, 8'h02);
      pulse(3); rd(4'h0, v); chk("R7 tmo", v, 8'h22);
      pulse(1); rd(4'h0, v); chk("R7 perr", v, 8'h26);
      wr(4'h0, 8'h02);
      rd(4'h0, v); chk("R8 clear", v, 8'h00);
      wr(4'h0, 8'h08);
      rd(4'h0, v); chk("R9 force", v, 8'h10);
   endtask

   task automatic t_block();
      logic [7:0] v;
      wr(4'h0, 8'h01);
      for (int i = 0; i < 33; i++) wr(4'h9, 8'hA0 + 8'(i));
      eng_buf_raddr = 5'd0; #1 chk("R10 wrap overwrite", eng_buf_rdata, 8'hC0);
      eng_buf_raddr = 5'd1; #1 chk("R10 entry1", eng_buf_rdata, 8'hA1);
      eng_buf_raddr = 5'd31; #1 chk("R10 entry31", eng_buf_rdata, 8'hBF);
      rd(4'h9, v); chk("R10 next index", v, 8'hA1);
      wr(4'h0, 8'h00);
      rd(4'h9, v); chk("R9 index reset", v, 8'hC0);
      rd(4'h9, v); chk("R10 read advance", v, 8'hA1);
      wr(4'h0, 8'h10);
      rd(4'h9, v); chk("R8 index reset", v, 8'hC0);
      @(negedge clk);
      eng_buf_we = 1; eng_buf_waddr = 5'd1; eng_buf_wdata = 8'h5A;
      @(negedge clk);
      eng_buf_we = 0;
      rd(4'h9, v); chk("R10 engine write", v, 8'h5A);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(4'h2, 8'h00); wr(4'h0, 8'h37);
      chk("R12 low", irq, 0);
      wr(4'h2, 8'h11);
      chk("R11 no cause", irq, 0);
      wr(4'h2, 8'h19);
      chk("R11 busy only", irq, 0);
      pulse(0);
      chk("R11 done irq", irq, 1);
      wr(4'h0, 8'h10);
      chk("R12 no new bit", irq, 0);
      rd(4'h0, v); chk("R8 cleared", v, 8'h00);
      wr(4'h0, 8'h04);
      chk("R12 new bit", irq, 1);
      wr(4'h0, 8'h00);
      chk("R12 plain lowers", irq, 0);
      wr(4'h2, 8'h09);
      pulse(0);
      chk("R11 disabled", irq, 0);
      wr(4'h0, 8'h37);
      wr(4'h2, 8'h1C);
      chk("R11 bad type irq", irq, 1);
      wr(4'h2, 8'h00); wr(4'h0, 8'h37);
   endtask

   task automatic t_unmapped();
      logic [7:0] v;
      wr(4'h4, 8'h5B); wr(4'h2, 8'h03);
      wr(4'h0, 8'h00);
      for (int a = 10; a < 16; a++) wr(a[3:0], 8'hFF);
      wr(4'h1, 8'hFF); wr(4'h3, 8'hFF); wr(4'h5, 8'hFF);
      for (int a = 10; a < 16; a++) begin
         rd(a[3:0], v); chk("R14 reads zero", v, 8'h00);
      end
      rd(4'h3, v); chk("R14 ofs3", v, 8'h00);
      rd(4'h5, v); chk("R14 ofs5", v, 8'h00);
      rd(4'h0, v); chk("R14 status kept", v, 8'h10);
      rd(4'h4, v); chk("R14 haddr kept", v, 8'h5B);
      rd(4'h2, v); chk("R14 ctl kept", v, 8'h03);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_regs();
      t_ctl_read();
      t_launch();
      t_abort_flags();
      t_block();
      t_irq();
      t_unmapped();
      finished = 1;
   end

   initial begin
      for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
      end
      #2;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule